// File: doc/BRIEF.md
# Go-back-N Sender Controller

This block runs the transmit side of a sliding-window link that recovers from errors by going back to the rejected frame. It numbers outgoing information frames modulo 2^SEQ_W, keeps track of which frames the peer has not yet acknowledged, and tells the framer which sequence number to put on the line next. Frame payloads live in a separate buffer. The framer reads `tx_seq` and `tx_resend` to pick the stored copy or a fresh frame, and `tx_poll` to build a supervisory ready frame with the poll bit set.

Acknowledgments arrive already decoded as a kind and a number. A receive-ready acknowledges all frames before its number. A receive-not-ready does the same but also stops data. A reject sends the sender back to the named frame. If an acknowledgment does not come in time, the block does not resend data blindly. It polls the peer and waits for the reply. If the peer stays silent after a set number of polls, the block raises a link reset request.

Top module: `gbn_tx_ctrl`

## Requirements
- R1: Two cycles after reset is released, `tx_req`, `outstanding`, `peer_busy` and `link_reset_req` are all 0, and the first new frame carries sequence 0.
- R2: New frames (`tx_req` with `tx_resend`=0 and `tx_poll`=0) take consecutive sequence numbers that wrap from 2^SEQ_W-1 back to 0. Each accepted new frame raises `outstanding` by one.
- R3: `outstanding` never exceeds WIN. While it equals WIN, no new frame is requested.
- R4: A receive-ready (`ack_kind`=2'b00) carrying N acknowledges every frame before N, so `outstanding` becomes (next unsent − N) mod 2^SEQ_W.
- R5: A reject (`ack_kind`=2'b10) carrying N makes the block request frames N, N+1, … up to the last frame sent, in order, with `tx_resend`=1. New frames follow after that.
- R6: A receive-not-ready (`ack_kind`=2'b01) carrying N acknowledges the frames before N and sets `peer_busy`. No data frame is requested until a receive-ready or a reject arrives.
- R7: When frames stay unacknowledged and nothing advances the window for ACK_TMO cycles, the block requests a poll (`tx_poll`=1), with `tx_seq` showing the oldest unacknowledged frame.
- R8: A valid acknowledgment carrying N that answers a poll ends the poll state. Data then restarts at frame N, resent with `tx_resend`=1.
- R9: A poll left unanswered for POLL_TMO cycles is repeated. After MAX_POLL unanswered polls, `link_reset_req` rises and stays high until reset, and `tx_req` stays low.
- R10: An acknowledgment whose number lies outside the range from the oldest unacknowledged frame to the next unsent frame is ignored. So is one of kind 2'b11.
- R11: A repeated receive-ready changes nothing. A second reject is ignored until the window base has moved forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| new_avail | input | 1 | A fresh frame is waiting to be sent |
| tx_ready | input | 1 | Framer takes the current request on this edge |
| ack_valid | input | 1 | A decoded acknowledgment is present |
| ack_kind | input | 2 | 00 receive-ready, 01 receive-not-ready, 10 reject, 11 ignored |
| ack_num | input | SEQ_W | Next sequence number the peer expects |
| tx_req | output | 1 | A frame or a poll should be sent |
| tx_seq | output | SEQ_W | Sequence number of the requested frame (the oldest unacknowledged frame for a poll) |
| tx_resend | output | 1 | The request is a copy of a frame sent earlier |
| tx_poll | output | 1 | The request is a ready poll command |
| outstanding | output | SEQ_W | Frames sent and not yet acknowledged |
| peer_busy | output | 1 | Peer has signalled receive-not-ready |
| link_reset_req | output | 1 | Polling gave up; the link needs a reset |

## Verification
A corrupted window base or next-unsent pointer is visible at once in `outstanding` and in the sequence number of the next new frame. A wrong resend pointer shows on the first request after a reject or a poll reply, as a bad `tx_seq` or a missing `tx_resend`. Faults in the recovery timer show up as a poll arriving on a different cycle than ACK_TMO after the last window progress, or as the wrong number of polls before `link_reset_req` rises. Ignored acknowledgments are checked by confirming that `outstanding` and the requests stay unchanged in the following cycle.

// File: rtl/gbn_pkg.sv
package gbn_pkg;

  typedef enum logic [1:0] {
    ACK_RR  = 2'b00,
    ACK_RNR = 2'b01,
    ACK_REJ = 2'b10,
    ACK_RSV = 2'b11
  } ack_kind_e;

  typedef enum logic [1:0] {
    M_IDLE      = 2'b00,
    M_POLL_SEND = 2'b01,
    M_POLL_WAIT = 2'b10,
    M_DOWN      = 2'b11
  } rec_mode_e;

endpackage

// File: rtl/gbn_seq_window.sv
module gbn_seq_window
  import gbn_pkg::*;
#(
  parameter int SEQ_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_valid,
  input  logic [1:0]       ack_kind,
  input  logic [SEQ_W-1:0] ack_num,
  input  logic             fire_data,
  input  logic             fire_new,
  input  logic             polling,
  output logic [SEQ_W-1:0] base,
  output logic [SEQ_W-1:0] next_new,
  output logic [SEQ_W-1:0] send_ptr,
  output logic [SEQ_W-1:0] outstanding,
  output logic             busy,
  output logic             progress,
  output logic             ack_ok
);

  localparam logic [SEQ_W-1:0] ONE = {{(SEQ_W-1){1'b0}}, 1'b1};

  logic [SEQ_W-1:0] base_q, base_d;
  logic [SEQ_W-1:0] nn_q, nn_d;
  logic [SEQ_W-1:0] sp_q, sp_d;
  logic             busy_q, busy_d;
  logic             rej_hold_q, rej_hold_d;
  logic             upd_en;

  logic [SEQ_W-1:0] off_n, off_s, sp_inc;
  logic             kind_known, rej_take, rewind, advance;

  always_comb begin
    outstanding = nn_q - base_q;
    off_n       = ack_num - base_q;
    kind_known  = (ack_kind != ACK_RSV);
    ack_ok      = ack_valid && kind_known && (off_n <= outstanding);
    rej_take    = ack_ok && (ack_kind == ACK_REJ) && !rej_hold_q;
    rewind      = rej_take || (ack_ok && polling);
    advance     = ack_ok && (ack_num != base_q);
    progress    = advance || rej_take;

    sp_inc = fire_data ? (sp_q + ONE) : sp_q;
    off_s  = sp_inc - base_q;

    base_d = ack_ok ? ack_num : base_q;
    nn_d   = fire_new ? (nn_q + ONE) : nn_q;

    if (rewind) begin
      sp_d = ack_num;
    end else if (ack_ok && (off_n > off_s)) begin
      sp_d = ack_num;
    end else begin
      sp_d = sp_inc;
    end

    busy_d = ack_ok ? (ack_kind == ACK_RNR) : busy_q;

    if (rej_take) begin
      rej_hold_d = 1'b1;
    end else if (advance) begin
      rej_hold_d = 1'b0;
    end else begin
      rej_hold_d = rej_hold_q;
    end

    upd_en = ack_valid || fire_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      nn_q       <= '0;
      sp_q       <= '0;
      busy_q     <= 1'b0;
      rej_hold_q <= 1'b0;
    end else if (upd_en) begin
      base_q     <= base_d;
      nn_q       <= nn_d;
      sp_q       <= sp_d;
      busy_q     <= busy_d;
      rej_hold_q <= rej_hold_d;
    end
  end

  assign base     = base_q;
  assign next_new = nn_q;
  assign send_ptr = sp_q;
  assign busy     = busy_q;

endmodule

// File: rtl/gbn_recovery.sv
module gbn_recovery
  import gbn_pkg::*;
#(
  parameter int ACK_TMO  = 64,
  parameter int POLL_TMO = 32,
  parameter int MAX_POLL = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pending,
  input  logic      progress,
  input  logic      ack_ok,
  input  logic      poll_fire,
  output rec_mode_e mode
);

  localparam int TMAX = (ACK_TMO > POLL_TMO) ? ACK_TMO : POLL_TMO;
  localparam int TW   = (TMAX > 1) ? $clog2(TMAX) : 1;
  localparam int AW   = $clog2(MAX_POLL + 1);
  localparam logic [TW-1:0] ACK_LIM  = TW'(ACK_TMO - 1);
  localparam logic [TW-1:0] POLL_LIM = TW'(POLL_TMO - 1);
  localparam logic [AW-1:0] TRY_LIM  = AW'(MAX_POLL);
  localparam logic [AW-1:0] TRY_ONE  = AW'(1);

  rec_mode_e     mode_q, mode_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [AW-1:0] tries_q, tries_d;

  always_comb begin
    mode_d  = mode_q;
    tmr_d   = tmr_q;
    tries_d = tries_q;
    unique case (mode_q)
      M_IDLE: begin
        if (!pending || progress) begin
          tmr_d = '0;
        end else if (tmr_q == ACK_LIM) begin
          mode_d  = M_POLL_SEND;
          tmr_d   = '0;
          tries_d = TRY_ONE;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      M_POLL_SEND: begin
        if (ack_ok) begin
          mode_d  = M_IDLE;
          tmr_d   = '0;
          tries_d = '0;
        end else if (poll_fire) begin
          mode_d = M_POLL_WAIT;
          tmr_d  = '0;
        end
      end
      M_POLL_WAIT: begin
        if (ack_ok) begin
          mode_d  = M_IDLE;
          tmr_d   = '0;
          tries_d = '0;
        end else if (tmr_q == POLL_LIM) begin
          tmr_d = '0;
          if (tries_q == TRY_LIM) begin
            mode_d = M_DOWN;
          end else begin
            mode_d  = M_POLL_SEND;
            tries_d = tries_q + 1'b1;
          end
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: begin
        mode_d = M_DOWN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_IDLE;
      tmr_q   <= '0;
      tries_q <= '0;
    end else begin
      mode_q  <= mode_d;
      tmr_q   <= tmr_d;
      tries_q <= tries_d;
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/gbn_tx_select.sv
module gbn_tx_select
  import gbn_pkg::*;
#(
  parameter int SEQ_W = 3,
  parameter int WIN   = 7
) (
  input  rec_mode_e        mode,
  input  logic             busy,
  input  logic [SEQ_W-1:0] base,
  input  logic [SEQ_W-1:0] send_ptr,
  input  logic [SEQ_W-1:0] next_new,
  input  logic [SEQ_W-1:0] outstanding,
  input  logic             new_avail,
  input  logic             tx_ready,
  output logic             tx_req,
  output logic [SEQ_W-1:0] tx_seq,
  output logic             tx_resend,
  output logic             tx_poll,
  output logic             fire_data,
  output logic             fire_new,
  output logic             poll_fire
);

  localparam logic [SEQ_W:0] WIN_V = (SEQ_W+1)'(WIN);

  logic room;
  logic fire;

  always_comb begin
    room      = ({1'b0, outstanding} < WIN_V);
    tx_req    = 1'b0;
    tx_seq    = send_ptr;
    tx_resend = 1'b0;
    tx_poll   = 1'b0;
    unique case (mode)
      M_POLL_SEND: begin
        tx_req  = 1'b1;
        tx_poll = 1'b1;
        tx_seq  = base;
      end
      M_IDLE: begin
        if (!busy) begin
          if (send_ptr != next_new) begin
            tx_req    = 1'b1;
            tx_resend = 1'b1;
          end else if (new_avail && room) begin
            tx_req = 1'b1;
          end
        end
      end
      default: begin
        tx_req = 1'b0;
      end
    endcase
    fire      = tx_req && tx_ready;
    poll_fire = fire && tx_poll;
    fire_data = fire && !tx_poll;
    fire_new  = fire_data && !tx_resend;
  end

endmodule

// File: rtl/gbn_tx_ctrl.sv
module gbn_tx_ctrl
  import gbn_pkg::*;
#(
  parameter int SEQ_W    = 3,
  parameter int WIN      = 7,
  parameter int ACK_TMO  = 64,
  parameter int POLL_TMO = 32,
  parameter int MAX_POLL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             new_avail,
  input  logic             tx_ready,
  input  logic             ack_valid,
  input  logic [1:0]       ack_kind,
  input  logic [SEQ_W-1:0] ack_num,
  output logic             tx_req,
  output logic [SEQ_W-1:0] tx_seq,
  output logic             tx_resend,
  output logic             tx_poll,
  output logic [SEQ_W-1:0] outstanding,
  output logic             peer_busy,
  output logic             link_reset_req
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  rec_mode_e        mode;
  logic [SEQ_W-1:0] base, next_new, send_ptr;
  logic             busy, progress, ack_ok;
  logic             fire_data, fire_new, poll_fire;
  logic             polling;

  assign polling = (mode == M_POLL_SEND) || (mode == M_POLL_WAIT);

  gbn_seq_window #(.SEQ_W(SEQ_W)) u_win (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ack_valid  (ack_valid),
    .ack_kind   (ack_kind),
    .ack_num    (ack_num),
    .fire_data  (fire_data),
    .fire_new   (fire_new),
    .polling    (polling),
    .base       (base),
    .next_new   (next_new),
    .send_ptr   (send_ptr),
    .outstanding(outstanding),
    .busy       (busy),
    .progress   (progress),
    .ack_ok     (ack_ok)
  );

  gbn_recovery #(
    .ACK_TMO (ACK_TMO),
    .POLL_TMO(POLL_TMO),
    .MAX_POLL(MAX_POLL)
  ) u_rec (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pending  (outstanding != '0),
    .progress (progress),
    .ack_ok   (ack_ok),
    .poll_fire(poll_fire),
    .mode     (mode)
  );

  gbn_tx_select #(.SEQ_W(SEQ_W), .WIN(WIN)) u_sel (
    .mode       (mode),
    .busy       (busy),
    .base       (base),
    .send_ptr   (send_ptr),
    .next_new   (next_new),
    .outstanding(outstanding),
    .new_avail  (new_avail),
    .tx_ready   (tx_ready),
    .tx_req     (tx_req),
    .tx_seq     (tx_seq),
    .tx_resend  (tx_resend),
    .tx_poll    (tx_poll),
    .fire_data  (fire_data),
    .fire_new   (fire_new),
    .poll_fire  (poll_fire)
  );

  assign peer_busy      = busy;
  assign link_reset_req = (mode == M_DOWN);

endmodule

// File: rtl/gbn_tx_ctrl_chk.sv
module gbn_tx_ctrl_chk #(
  parameter int SEQ_W = 3,
  parameter int WIN   = 7
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             tx_ready,
  input logic             ack_valid,
  input logic             tx_req,
  input logic             tx_resend,
  input logic             tx_poll,
  input logic [SEQ_W-1:0] outstanding,
  input logic             peer_busy,
  input logic             link_reset_req
);

  AST_WIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ({1'b0, outstanding} <= (SEQ_W+1)'(WIN))); // R3

  AST_FULL_NO_NEW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (({1'b0, outstanding} == (SEQ_W+1)'(WIN)) && tx_req) |-> (tx_resend || tx_poll)); // R3

  AST_NEW_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_req && tx_ready && !tx_resend && !tx_poll && !ack_valid)
      |=> (outstanding == SEQ_W'($past(outstanding) + 1'b1))); // R2

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (peer_busy && tx_req) |-> tx_poll); // R6

  AST_KIND_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_req |-> $onehot0({tx_resend, tx_poll})); // R5

  AST_KIND_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tx_req |-> (!tx_resend && !tx_poll)); // R5

  AST_DOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    link_reset_req |=> link_reset_req); // R9

  AST_DOWN_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    link_reset_req |-> !tx_req); // R9

endmodule

bind gbn_tx_ctrl gbn_tx_ctrl_chk #(.SEQ_W(SEQ_W), .WIN(WIN)) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .tx_ready      (tx_ready),
  .ack_valid     (ack_valid),
  .tx_req        (tx_req),
  .tx_resend     (tx_resend),
  .tx_poll       (tx_poll),
  .outstanding   (outstanding),
  .peer_busy     (peer_busy),
  .link_reset_req(link_reset_req)
);

// File: tb/gbn_tx_ctrl_tb.sv
module gbn_tx_ctrl_tb;

  localparam int CLK_P    = 10;
  localparam int SEQ_W    = 3;
  localparam int WIN      = 7;
  localparam int ACK_TMO  = 40;
  localparam int POLL_TMO = 12;
  localparam int MAX_POLL = 3;

  // vector: [13:10] new frames to send, [9:8] ack kind, [7:5] ack number,
  //         [4:1] expected outstanding, [0] expected peer_busy
  localparam logic [13:0] VEC [8] = '{
    {4'd3, 2'b00, 3'd2, 4'd1, 1'b0},
    {4'd2, 2'b00, 3'd5, 4'd0, 1'b0},
    {4'd4, 2'b00, 3'd6, 4'd3, 1'b0},
    {4'd0, 2'b00, 3'd0, 4'd1, 1'b0},
    {4'd0, 2'b00, 3'd5, 4'd1, 1'b0},
    {4'd0, 2'b00, 3'd0, 4'd1, 1'b0},
    {4'd2, 2'b01, 3'd2, 4'd1, 1'b1},
    {4'd0, 2'b00, 3'd3, 4'd0, 1'b0}
  };

  logic             clk;
  logic             rst_n;
  logic             new_avail;
  logic             tx_ready;
  logic             ack_valid;
  logic [1:0]       ack_kind;
  logic [SEQ_W-1:0] ack_num;
  logic             tx_req;
  logic [SEQ_W-1:0] tx_seq;
  logic             tx_resend;
  logic             tx_poll;
  logic [SEQ_W-1:0] outstanding;
  logic             peer_busy;
  logic             link_reset_req;

  int checks;
  int errors;
  logic [SEQ_W-1:0] exp_seq;

  gbn_tx_ctrl #(
    .SEQ_W(SEQ_W), .WIN(WIN), .ACK_TMO(ACK_TMO),
    .POLL_TMO(POLL_TMO), .MAX_POLL(MAX_POLL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .new_avail(new_avail), .tx_ready(tx_ready),
    .ack_valid(ack_valid), .ack_kind(ack_kind), .ack_num(ack_num),
    .tx_req(tx_req), .tx_seq(tx_seq), .tx_resend(tx_resend), .tx_poll(tx_poll),
    .outstanding(outstanding), .peer_busy(peer_busy), .link_reset_req(link_reset_req)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    new_avail = 1'b0;
    tx_ready  = 1'b1;
    ack_valid = 1'b0;
    ack_kind  = 2'b00;
    ack_num   = '0;
    exp_seq   = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    #1;
  endtask

  task automatic send_new(input int n, input string req);
    int got;
    int guard;
    got   = 0;
    guard = 0;
    new_avail = 1'b1;
    #1;
    while (got < n && guard < 100) begin
      if (tx_req && !tx_resend && !tx_poll) begin
        chk(req, int'(tx_seq), int'(exp_seq));
        exp_seq = exp_seq + 1'b1;
        got++;
      end
      step();
      guard++;
      #1;
    end
    new_avail = 1'b0;
    #1;
    chk(req, got, n);
  endtask

  task automatic ack(input logic [1:0] kind, input logic [SEQ_W-1:0] num);
    ack_valid = 1'b1;
    ack_kind  = kind;
    ack_num   = num;
    step();
    ack_valid = 1'b0;
    #1;
  endtask

  function automatic string vec_tag(input int i);
    case (i)
      4:       return "R10 out-of-range ack ignored";
      5:       return "R11 repeated RR no effect";
      6:       return "R6 RNR acks and halts";
      default: return "R4 RR cumulative ack";
    endcase
  endfunction

  initial begin
    checks = 0;
    errors = 0;
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c;
    int polls;
    do_reset();

    // R1: reset state
    chk("R1 tx_req after reset", int'(tx_req), 0);
    chk("R1 outstanding after reset", int'(outstanding), 0);
    chk("R1 peer_busy after reset", int'(peer_busy), 0);
    chk("R1 link_reset_req after reset", int'(link_reset_req), 0);

    // table walk: R2 numbering with wrap, R4, R6, R10, R11
    for (int i = 0; i < 8; i++) begin
      logic [13:0] v;
      v = VEC[i];
      if (v[13:10] != 4'd0) send_new(int'(v[13:10]), "R2 consecutive new sequence");
      ack(v[9:8], v[7:5]);
      chk(vec_tag(i), int'(outstanding), int'(v[4:1]));
      chk(vec_tag(i), int'(peer_busy), int'(v[0]));
      if (v[0]) begin
        new_avail = 1'b1;
        #1;
        chk("R6 no data while busy", int'(tx_req), 0);
        new_avail = 1'b0;
        #1;
      end
    end

    // R3: window limit
    do_reset();
    new_avail = 1'b1;
    #1;
    c = 0;
    for (int k = 0; k < 12; k++) begin
      if (tx_req && !tx_resend && !tx_poll) begin
        chk("R3 new sequence under window", int'(tx_seq), int'(exp_seq));
        exp_seq = exp_seq + 1'b1;
        c++;
      end
      step();
      #1;
    end
    chk("R3 frames sent before full", c, WIN);
    chk("R3 outstanding at full", int'(outstanding), WIN);
    chk("R3 no request when full", int'(tx_req), 0);
    new_avail = 1'b0;
    #1;

    // R5: reject rewinds and resends in order
    ack(2'b10, 3'd3);
    chk("R5 outstanding after reject", int'(outstanding), 4);
    for (int k = 0; k < 4; k++) begin
      chk("R5 resend request", int'(tx_req), 1);
      chk("R5 resend flag", int'(tx_resend), 1);
      chk("R5 resend sequence", int'(tx_seq), 3 + k);
      step();
      #1;
    end
    chk("R5 resends done", int'(tx_req), 0);
    new_avail = 1'b1;
    #1;
    chk("R5 new after resends", int'(tx_resend), 0);
    chk("R5 new sequence after resends", int'(tx_seq), 7);
    step();
    new_avail = 1'b0;
    #1;
    chk("R5 outstanding after new frame", int'(outstanding), 5);

    // R11: second reject before progress is ignored
    ack(2'b10, 3'd3);
    chk("R11 repeated reject ignored", int'(tx_req), 0);
    chk("R11 outstanding unchanged", int'(outstanding), 5);

    // R10: unknown kind ignored
    ack(2'b11, 3'd6);
    chk("R10 reserved kind ignored", int'(outstanding), 5);

    // R7: poll after ACK_TMO cycles without progress
    ack(2'b00, 3'd4);
    chk("R4 RR after resends", int'(outstanding), 4);
    c = 0;
    while (!tx_poll && c < 200) begin
      step();
      #1;
      c++;
    end
    chk("R7 cycles until poll", c, ACK_TMO);
    chk("R7 poll shows oldest frame", int'(tx_seq), 4);

    // R9: repeated polls then link reset request
    polls = 0;
    c = 0;
    while (!link_reset_req && c < 300) begin
      if (tx_poll) polls++;
      step();
      #1;
      c++;
    end
    chk("R9 poll count before giving up", polls, MAX_POLL);
    chk("R9 link reset raised", int'(link_reset_req), 1);
    new_avail = 1'b1;
    #1;
    chk("R9 silent after giving up", int'(tx_req), 0);
    repeat (3) step();
    #1;
    chk("R9 link reset sticky", int'(link_reset_req), 1);
    new_avail = 1'b0;

    // R8: poll answered, data restarts at the acknowledged number
    do_reset();
    send_new(3, "R2 new frames before poll");
    c = 0;
    while (!tx_poll && c < 200) begin
      step();
      #1;
      c++;
    end
    chk("R7 poll raised", int'(tx_poll), 1);
    step();
    #1;
    ack(2'b00, 3'd1);
    chk("R8 resend after poll reply", int'(tx_resend), 1);
    chk("R8 resend sequence first", int'(tx_seq), 1);
    step();
    #1;
    chk("R8 resend sequence second", int'(tx_seq), 2);
    chk("R8 second is resend", int'(tx_resend), 1);
    step();
    #1;
    chk("R8 no more requests", int'(tx_req), 0);
    chk("R8 link stays up", int'(link_reset_req), 0);
    chk("R8 outstanding after reply", int'(outstanding), 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule